// File: doc/BRIEF.md
# Wide Register Atomic Byte Access Buffer

This block lets a byte-wide register port reach registers that are 16 or 24 bits wide without tearing their values. Each wide register is cut into byte pieces (low, middle and high, with the middle piece present only on 24-bit registers). Each piece has its own byte address. The port side supplies an address, read and write strobes, a write byte and a stop pulse that marks the end of a bus transaction. The register side supplies the live value of every wide register and receives write commits.

A read of the low byte returns the live low byte and freezes the other bytes of that register. Later reads of those bytes return the frozen copy, so a value that changes between accesses still reads back as one coherent sample. A write of the low byte opens a staging buffer. The remaining bytes collect there, and the whole value is committed as a single pulse once every byte has arrived. A stop pulse drops any frozen copy or partial staging. A middle or high access that no low access came before goes straight to the live register.

Top module: `mbr_atomic_buf`

## Requirements
- R1: Register i sits at byte addresses BASE_ADDR+4*i+k. Offset k=0 is the low byte (value bits 7:0). Offset k=1 is the middle byte (bits 15:8) and exists only on 24-bit registers. Offset k=2 is the high byte: bits 23:16 on a 24-bit register and bits 15:8 on a 16-bit one. Offset 3, the middle offset of a 16-bit register, and any address outside the register range are unmapped. Reads of them return 0x00 and writes to them produce no commit.
- R2: For every accepted read, the requested byte appears on the read data output with the valid flag high, one clock after the read strobe.
- R3: A low-byte read returns the live low byte and captures the other bytes of that register. Later middle or high reads of the same register return the captured bytes, even after the live value has changed.
- R4: The capture ends once each captured byte has been read at least once. From then on, reads of that register return live bytes.
- R5: A middle or high read with no capture held for that register returns the live byte.
- R6: A low-byte write starts staging for that register and produces no commit. The commit comes one clock after the last missing byte is written, whatever order the bytes arrive in. It is a one-cycle pulse carrying the register index, the assembled value and byte mask 3'b111 for a 24-bit register or 3'b011 for a 16-bit one.
- R7: A middle or high write with no staging open for that register commits at once, one clock later. The commit has a single-bit byte mask at the byte's value position, and all other value bits are zero.
- R8: A stop pulse discards both the capture and the staging. Later middle or high reads return live bytes, and later middle or high writes commit directly under R7.
- R9: Any low-byte access, read or write, to any register abandons a capture or staging that is still open. A write then opens only staging, and a read opens only a capture.
- R10: An access in the same cycle as stop is ignored: no read data and no commit. When read and write strobes are both high, only the read is serviced and the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Byte address of the access |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_byte | input | 8 | Write data byte |
| xfer_stop | input | 1 | End-of-transaction pulse; discards open buffers |
| live_flat | input | NUM_REGS*24 | Live register values, register i in bits 24*i+23:24*i |
| rd_byte | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid pulse |
| commit_valid | output | 1 | Write commit pulse |
| commit_idx | output | IDX_W | Register index of the commit |
| commit_val | output | 24 | Committed value, bytes outside the mask zero |
| commit_be | output | 3 | Byte mask of the committed value |

## Verification
If the capture keeps the wrong bytes or is released at the wrong time, the very next middle or high read of that register shows it. It returns a stale byte where a live one belongs, or the reverse, one clock after the strobe. Wrong staging shows up on the commit outputs. It may appear as a direct single-byte commit where nothing should appear, or as a missing or early atomic pulse, and in either case on the clock after the offending write. The bench therefore changes the live values between accesses and interleaves stop pulses and low-byte accesses to other registers, so that every wrong state shows up in the very next access.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam int BYTE_W    = 8;
    localparam int VAL_W     = 24;
    localparam int MAX_IDX_W = 4;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [VAL_W-1:0]  wide_t;

    // byte offset inside a register slot; order is fixed by the address map
    typedef enum logic [1:0] {
        LANE_LO   = 2'd0,
        LANE_MID  = 2'd1,
        LANE_HI   = 2'd2,
        LANE_NONE = 2'd3
    } lane_e;

    typedef struct packed {
        logic                 hit;
        logic [MAX_IDX_W-1:0] idx;
        lane_e                lane;
        logic [1:0]           bsel;   // byte position inside the value
        logic                 is24;
    } dec_t;

    typedef struct packed {
        logic                 valid;
        logic [MAX_IDX_W-1:0] idx;
        wide_t                val;
        logic [2:0]           mask;
    } commit_t;

    // value byte reached by an address lane
    function automatic logic [1:0] lane_byte(lane_e l, logic is24);
        case (l)
            LANE_LO:  return 2'd0;
            LANE_MID: return 2'd1;
            default:  return is24 ? 2'd2 : 2'd1;
        endcase
    endfunction

    function automatic byte_t pick_byte(wide_t v, logic [1:0] b);
        case (b)
            2'd0:    return v[7:0];
            2'd1:    return v[15:8];
            default: return v[23:16];
        endcase
    endfunction

    function automatic wide_t put_byte(wide_t v, byte_t d, logic [1:0] b);
        wide_t r;
        r = v;
        case (b)
            2'd0:    r[7:0]   = d;
            2'd1:    r[15:8]  = d;
            default: r[23:16] = d;
        endcase
        return r;
    endfunction

    function automatic logic [2:0] full_mask(logic is24);
        return is24 ? 3'b111 : 3'b011;
    endfunction

endpackage

// File: rtl/mbr_decode.sv
module mbr_decode
    import mbr_pkg::*;
#(
    parameter int              NUM_REGS    = 4,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
    parameter logic [NUM_REGS-1:0] WIDE24_MASK = 4'b0101
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int SLOT_W = ADDR_W - 2;

    logic [ADDR_W-1:0] off;
    logic [SLOT_W-1:0] slot;
    lane_e             lane_raw;

    assign off      = addr_i - BASE_ADDR;
    assign slot     = off[ADDR_W-1:2];
    assign lane_raw = lane_e'(off[1:0]);

    always_comb begin
        dec_o      = '0;
        dec_o.lane = LANE_NONE;
        if (addr_i >= BASE_ADDR) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (slot == SLOT_W'(i)) begin
                    dec_o.idx  = MAX_IDX_W'(i);
                    dec_o.is24 = WIDE24_MASK[i];
                    if (lane_raw != LANE_NONE &&
                        (lane_raw != LANE_MID || WIDE24_MASK[i])) begin
                        dec_o.hit  = 1'b1;
                        dec_o.lane = lane_raw;
                        dec_o.bsel = lane_byte(lane_raw, WIDE24_MASK[i]);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mbr_read_hold.sv
module mbr_read_hold
    import mbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stop_i,
    input  logic  rd_i,      // accepted, mapped read
    input  logic  lo_wr_i,   // accepted low-byte write
    input  dec_t  dec_i,
    input  wide_t live_i,    // live value of the decoded register
    output byte_t rd_byte_o
);
    logic                 act;
    logic [MAX_IDX_W-1:0] idx;
    wide_t                hval;
    logic [2:0]           pend;
    logic                 use_hold;
    logic [2:0]           pend_nx;

    assign use_hold = act && (idx == dec_i.idx) && (dec_i.lane != LANE_LO);
    assign pend_nx  = pend & ~(3'b001 << dec_i.bsel);

    always_comb begin
        if (!dec_i.hit)    rd_byte_o = '0;
        else if (use_hold) rd_byte_o = pick_byte(hval, dec_i.bsel);
        else               rd_byte_o = pick_byte(live_i, dec_i.bsel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            idx  <= '0;
            hval <= '0;
            pend <= '0;
        end else if (stop_i) begin
            act  <= 1'b0;
            pend <= '0;
        end else if (rd_i && dec_i.lane == LANE_LO) begin
            act  <= 1'b1;
            idx  <= dec_i.idx;
            hval <= live_i;
            pend <= dec_i.is24 ? 3'b110 : 3'b010;
        end else if (lo_wr_i) begin
            act  <= 1'b0;
            pend <= '0;
        end else if (rd_i && use_hold) begin
            pend <= pend_nx;
            if (pend_nx == 3'b000) act <= 1'b0;
        end
    end

    // an open capture always has a byte left to deliver
    p_hold_pending_r4: assert property (@(posedge clk) disable iff (rst)
        act |-> (pend != 3'b000));

    p_stop_drops_hold_r8: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !act);
endmodule

// File: rtl/mbr_write_stage.sv
module mbr_write_stage
    import mbr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stop_i,
    input  logic    wr_i,     // accepted, mapped write
    input  logic    lo_rd_i,  // accepted low-byte read
    input  dec_t    dec_i,
    input  byte_t   wdata_i,
    output commit_t commit_o
);
    logic                 act;
    logic [MAX_IDX_W-1:0] idx;
    wide_t                sval;
    logic [2:0]           recv;
    logic [2:0]           need;
    logic                 match;
    wide_t                sval_nx;
    logic [2:0]           recv_nx;

    assign match   = act && (idx == dec_i.idx);
    assign sval_nx = put_byte(sval, wdata_i, dec_i.bsel);
    assign recv_nx = recv | (3'b001 << dec_i.bsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            act      <= 1'b0;
            idx      <= '0;
            sval     <= '0;
            recv     <= '0;
            need     <= '0;
            commit_o <= '0;
        end else begin
            commit_o.valid <= 1'b0;
            if (stop_i) begin
                act <= 1'b0;
            end else if (wr_i && dec_i.lane == LANE_LO) begin
                act  <= 1'b1;
                idx  <= dec_i.idx;
                sval <= put_byte('0, wdata_i, 2'd0);
                recv <= 3'b001;
                need <= full_mask(dec_i.is24);
            end else if (wr_i && match) begin
                if (recv_nx == need) begin
                    act      <= 1'b0;
                    commit_o <= '{valid: 1'b1, idx: idx, val: sval_nx, mask: need};
                end else begin
                    sval <= sval_nx;
                    recv <= recv_nx;
                end
            end else if (wr_i) begin
                commit_o <= '{valid: 1'b1, idx: dec_i.idx,
                              val: put_byte('0, wdata_i, dec_i.bsel),
                              mask: 3'b001 << dec_i.bsel};
            end else if (lo_rd_i) begin
                act <= 1'b0;
            end
        end
    end

    p_commit_from_write_r7: assert property (@(posedge clk) disable iff (rst)
        commit_o.valid |-> $past(wr_i));

    p_atomic_from_stage_r6: assert property (@(posedge clk) disable iff (rst)
        (commit_o.valid && $countones(commit_o.mask) > 1) |-> $past(act));

    p_stop_drops_stage_r8: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !act);
endmodule

// File: rtl/mbr_atomic_buf.sv
module mbr_atomic_buf
    import mbr_pkg::*;
#(
    parameter int                  NUM_REGS    = 4,
    parameter int                  ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]   BASE_ADDR   = 8'h40,
    parameter logic [NUM_REGS-1:0] WIDE24_MASK = 4'b0101,
    localparam int                 IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int                 LIVE_W      = NUM_REGS * VAL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    input  logic              xfer_stop,
    input  logic [LIVE_W-1:0] live_flat,
    output logic [7:0]        rd_byte,
    output logic              rd_valid,
    output logic              commit_valid,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [23:0]       commit_val,
    output logic [2:0]        commit_be
);
    dec_t    dec;
    wide_t   live_sel;
    byte_t   hold_byte;
    commit_t commit;
    logic    rd_eff, wr_eff, rd_hit, wr_hit;

    assign rd_eff = rd_en & ~xfer_stop;
    assign wr_eff = wr_en & ~rd_en & ~xfer_stop;
    assign rd_hit = rd_eff & dec.hit;
    assign wr_hit = wr_eff & dec.hit;

    mbr_decode #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
        .BASE_ADDR(BASE_ADDR), .WIDE24_MASK(WIDE24_MASK)
    ) u_dec (
        .addr_i(acc_addr),
        .dec_o (dec)
    );

    always_comb begin
        live_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec.idx == MAX_IDX_W'(i)) live_sel = live_flat[i*VAL_W +: VAL_W];
        end
    end

    mbr_read_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .stop_i   (xfer_stop),
        .rd_i     (rd_hit),
        .lo_wr_i  (wr_hit && dec.lane == LANE_LO),
        .dec_i    (dec),
        .live_i   (live_sel),
        .rd_byte_o(hold_byte)
    );

    mbr_write_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .stop_i  (xfer_stop),
        .wr_i    (wr_hit),
        .lo_rd_i (rd_hit && dec.lane == LANE_LO),
        .dec_i   (dec),
        .wdata_i (wr_byte),
        .commit_o(commit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_byte  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_eff;
            if (rd_eff) rd_byte <= hold_byte;
        end
    end

    assign commit_valid = commit.valid;
    assign commit_idx   = commit.idx[IDX_W-1:0];
    assign commit_val   = commit.val;
    assign commit_be    = commit.mask;

    p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en && !xfer_stop));

    p_stop_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        xfer_stop |=> (!rd_valid && !commit_valid));
endmodule

// File: tb/test_mbr_atomic_buf.sv
`timescale 1ns/1ps
module test_mbr_atomic_buf;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  idx;
        logic [23:0] val;
        logic [2:0]  mask;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  acc_addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, xfer_stop = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic [23:0] live [4];
    logic [95:0] live_flat;
    logic [7:0]  rd_byte;
    logic        rd_valid, commit_valid;
    logic [1:0]  commit_idx;
    logic [23:0] commit_val;
    logic [2:0]  commit_be;

    item_t rd_q[$];
    item_t cm_q[$];
    int checks = 0;
    int errors = 0;

    assign live_flat = {live[3], live[2], live[1], live[0]};

    always #5 clk = ~clk;

    mbr_atomic_buf i_mbr_atomic_buf (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_byte(wr_byte), .xfer_stop(xfer_stop), .live_flat(live_flat),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .commit_valid(commit_valid),
        .commit_idx(commit_idx), .commit_val(commit_val), .commit_be(commit_be)
    );

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                checks++;
                if (rd_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected read data %h, expected none", rd_byte);
                end else begin
                    item_t e;
                    e = rd_q.pop_front();
                    if (rd_byte !== e.val[7:0]) begin
                        errors++;
                        $display("FAIL R%0d read data %h, expected %h", e.req, rd_byte, e.val[7:0]);
                    end
                end
            end
            if (commit_valid) begin
                checks++;
                if (cm_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected commit idx %0d val %h be %b, expected none",
                             commit_idx, commit_val, commit_be);
                end else begin
                    item_t e;
                    e = cm_q.pop_front();
                    if (commit_idx !== e.idx || commit_val !== e.val || commit_be !== e.mask) begin
                        errors++;
                        $display("FAIL R%0d commit idx %0d val %h be %b, expected idx %0d val %h be %b",
                                 e.req, commit_idx, commit_val, commit_be, e.idx, e.val, e.mask);
                    end
                end
            end
        end
    end

    task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [7:0] d, input logic stp);
        acc_addr = a; rd_en = rd; wr_en = wr; wr_byte = d; xfer_stop = stp;
        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b0; xfer_stop = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input int r);
        rd_q.push_back('{req: 8'(r), idx: 2'd0, val: {16'h0, exp}, mask: 3'b0});
        step(1'b1, 1'b0, a, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic exp_cm(input logic [1:0] i, input logic [23:0] v,
                          input logic [2:0] m, input int r);
        cm_q.push_back('{req: 8'(r), idx: i, val: v, mask: m});
    endtask

    task automatic stop_pulse();
        step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired, expected run to complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        live[0] = 24'hA1B2C3; live[1] = 24'h00D4E5;
        live[2] = 24'h112233; live[3] = 24'h005566;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        checks++;
        if (rd_valid !== 1'b0 || commit_valid !== 1'b0) begin
            errors++;
            $display("FAIL reset rd_valid %b commit_valid %b, expected 0 0", rd_valid, commit_valid);
        end

        // R5 / R2: no capture, live bytes
        rd(8'h42, 8'hA1, 5);
        rd(8'h46, 8'hD4, 5);
        rd(8'h41, 8'hB2, 2);

        // R1: unmapped addresses
        rd(8'h43, 8'h00, 1);
        rd(8'h45, 8'h00, 1);
        rd(8'h50, 8'h00, 1);
        rd(8'h3F, 8'h00, 1);
        wr(8'h45, 8'h77);           // R1: no commit
        wr(8'h4B, 8'h77);           // R1: no commit

        // R3 / R4: 24-bit capture, then release
        rd(8'h40, 8'hC3, 3);
        live[0] = 24'h0F0E0D;
        rd(8'h42, 8'hA1, 3);
        rd(8'h41, 8'hB2, 3);
        rd(8'h41, 8'h0E, 4);

        // R3 / R4: 16-bit capture
        rd(8'h44, 8'hE5, 3);
        live[1] = 24'h00F0F1;
        rd(8'h46, 8'hD4, 3);
        rd(8'h46, 8'hF0, 4);

        // R8: stop drops capture
        rd(8'h48, 8'h33, 8);
        live[2] = 24'h445566;
        stop_pulse();
        rd(8'h49, 8'h55, 8);

        // R6: atomic writes, in order, 16-bit, and out of order
        wr(8'h48, 8'h01);
        wr(8'h49, 8'h02);
        exp_cm(2'd2, 24'h030201, 3'b111, 6);
        wr(8'h4A, 8'h03);
        wr(8'h4C, 8'hAA);
        exp_cm(2'd3, 24'h00BBAA, 3'b011, 6);
        wr(8'h4E, 8'hBB);
        wr(8'h40, 8'h10);
        wr(8'h42, 8'h30);
        exp_cm(2'd0, 24'h302010, 3'b111, 6);
        wr(8'h41, 8'h20);

        // R7: direct byte writes
        exp_cm(2'd0, 24'h005A00, 3'b010, 7);
        wr(8'h41, 8'h5A);
        exp_cm(2'd3, 24'h007700, 3'b010, 7);
        wr(8'h4E, 8'h77);
        exp_cm(2'd2, 24'hC30000, 3'b100, 7);
        wr(8'h4A, 8'hC3);

        // R8: stop drops staging
        wr(8'h48, 8'h01);
        stop_pulse();
        exp_cm(2'd2, 24'h000200, 3'b010, 8);
        wr(8'h49, 8'h02);
        exp_cm(2'd2, 24'h030000, 3'b100, 8);
        wr(8'h4A, 8'h03);

        // R9: low write to another register abandons staging
        wr(8'h40, 8'h01);
        wr(8'h4C, 8'h02);
        exp_cm(2'd0, 24'h000300, 3'b010, 9);
        wr(8'h41, 8'h03);
        exp_cm(2'd3, 24'h000402, 3'b011, 9);
        wr(8'h4E, 8'h04);
        // R9: low read to another register abandons capture
        rd(8'h40, 8'h0D, 9);
        rd(8'h48, 8'h66, 9);
        live[0] = 24'h999897;
        rd(8'h42, 8'h99, 9);
        // R9: low read abandons staging
        wr(8'h44, 8'h11);
        rd(8'h40, 8'h97, 9);
        exp_cm(2'd1, 24'h002200, 3'b010, 9);
        wr(8'h46, 8'h22);
        // R9: low write abandons capture
        live[2] = 24'h010203;
        rd(8'h48, 8'h03, 9);
        wr(8'h44, 8'h55);
        live[2] = 24'h0A0B0C;
        rd(8'h4A, 8'h0A, 9);

        // R10: access with stop ignored
        step(1'b1, 1'b0, 8'h40, 8'h00, 1'b1);
        live[0] = 24'h123456;
        rd(8'h41, 8'h34, 10);     // no capture was opened
        step(1'b0, 1'b1, 8'h41, 8'hEE, 1'b1);
        // R10: read and write together, write dropped
        rd_q.push_back('{req: 8'd10, idx: 2'd0, val: 24'h000012, mask: 3'b0});
        step(1'b1, 1'b1, 8'h42, 8'hEE, 1'b0);

        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rd_q.size() != 0) begin
            errors++;
            $display("FAIL R2 %0d reads missing, expected 0", rd_q.size());
        end
        checks++;
        if (cm_q.size() != 0) begin
            errors++;
            $display("FAIL R6 %0d commits missing, expected 0", cm_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule